// File: doc/BRIEF.md
# Paged SPI Configuration Register Bank

This block is a serial configuration slave that lets a host reach up to eight pages of 8-bit registers through one 5-bit address space. A page-select register at the top address of every page decides which page the other 31 addresses reach. Each populated page holds a group of read/write registers, whose contents drive the core logic through a flat configuration bus, and a group of read-only registers, which return status words supplied by the core.

The serial pins are oversampled by the system clock. SCLK and chip select are brought in through two-flop synchronizers, so SCLK must stay well below the system clock rate. A mode bit in register 0x00 of page 0 sets how the data pins are used. In 3-wire mode the data pin is bidirectional and read data comes back on it. In 4-wire mode the data pin is input only and read data appears on a separate output.

Top module: `cfg_page_bank`

## Requirements
- R1: A transfer is 16 SCLK rising edges while chip select is low, MSB first. The first bit is the direction (1 = read, 0 = write). Two ignored bits follow, then the 5-bit address, then 8 data bits. Inputs are sampled on SCLK rising edges. Read data bit 7 is presented after the 8th rising edge and the following bits are presented after each later falling edge. A write takes effect on the 16th rising edge. A transfer whose chip select rises before the 16th edge writes nothing.
- R2: While chip select is high, SCLK and data activity change no register, `sdio_oe` stays 0 and `sdo` stays 0.
- R3: When bit 0 of register 0x00 on page 0 is 1 (3-wire), read data is driven on `sdio_out` with `sdio_oe` = 1. The drive starts after the 8th rising edge of a read and lasts until chip select rises. `sdo` stays 0 in this mode.
- R4: When that bit is 0 (4-wire, the reset value), read data appears on `sdo` and `sdio_oe` stays 0.
- R5: Address 0x1F reaches the page-select register from every page. It is read/write and resets to 0x00. Its value selects the page that every other address reaches, starting with the next transfer.
- R6: On populated pages (0, 2, 4, 5, 6, 7), addresses 0x00 to 0x03 are read/write. Register k of page p drives `cfg_o[(p*4+k)*8 +: 8]` and reads back its last written value.
- R7: On populated pages, addresses 0x10 to 0x13 are read-only. Address 0x10+k of page p returns `status_i[(p*4+k)*8 +: 8]`. Writes to them are ignored.
- R8: A selected page of 1, 3 or any value above 7, and any address not listed above, reads as 0x00. Writes there leave `cfg_o` unchanged, and `cfg_o` is 0 for unpopulated pages.
- R9: Active-low `rst_n` returns all registers to 0x00. This selects page 0 and 4-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select framing a transfer |
| sdio_in | input | 1 | Serial data input |
| sdio_out | output | 1 | Serial data driven onto the shared pin in 3-wire mode |
| sdio_oe | output | 1 | Driver enable for the shared data pin |
| sdo | output | 1 | Serial read data in 4-wire mode |
| cfg_o | output | 256 | Read/write register contents, 8 pages of 4 bytes |
| status_i | input | 256 | Read-only register sources, 8 pages of 4 bytes |

## Verification
The hardest situation to reach is a read whose result depends on three earlier writes at once. The page register must have moved to a populated or unpopulated page, the mode bit on page 0 must have flipped the pin use, and the target must sit on a read-only or unused address. The random phase mixes page-register writes (including out-of-range pages), mode-bit writes and accesses to every address class. A bench model tracks page and mode, so each read is checked on the pin that mode selects. Directed cases add a transfer cut short at 12 bits and SCLK toggling with chip select high.

// File: rtl/cfg_page_bank.sv
module cfg_page_bank #(
  parameter int          NPAGES    = 8,
  parameter logic [7:0]  PAGE_MASK = 8'hF5,
  parameter int          RW_REGS   = 4,
  parameter int          RO_REGS   = 4,
  parameter int          RO_BASE   = 16,
  parameter int          CW        = NPAGES * RW_REGS * 8,
  parameter int          SW        = NPAGES * RO_REGS * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdio_in,
  output logic          sdio_out,
  output logic          sdio_oe,
  output logic          sdo,
  output logic [CW-1:0] cfg_o,
  input  logic [SW-1:0] status_i
);
  localparam int         PW        = $clog2(NPAGES);
  localparam int         RIW       = $clog2(RW_REGS);
  localparam logic [4:0] PAGE_ADDR = 5'h1F;

  logic [2:0] sclk_p, cs_p;
  logic [1:0] din_p;
  logic [4:0] cnt, addr_q;
  logic       is_rd;
  logic [6:0] sh;
  logic [7:0] out_sh, page_q, rd_val;
  logic [7:0] rw_q [NPAGES][RW_REGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= 3'b000;
      cs_p   <= 3'b111;
      din_p  <= 2'b00;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      din_p  <= {din_p[0], sdio_in};
    end

  wire rise   = sclk_p[1] & ~sclk_p[2];
  wire fall   = ~sclk_p[1] & sclk_p[2];
  wire active = ~cs_p[1];
  wire d      = din_p[1];

  wire [PW-1:0] pg         = page_q[PW-1:0];
  wire          page_ok    = (32'(page_q) < NPAGES) && PAGE_MASK[pg];
  wire [4:0]    addr_nx    = {sh[3:0], d};
  wire [7:0]    wdata      = {sh, d};
  wire          three_wire = rw_q[0][0][0];

  always_comb begin
    rd_val = 8'h00;
    if (addr_nx == PAGE_ADDR)
      rd_val = page_q;
    else if (page_ok) begin
      if (32'(addr_nx) < RW_REGS)
        rd_val = rw_q[pg][addr_nx[RIW-1:0]];
      else if (32'(addr_nx) >= RO_BASE && 32'(addr_nx) < RO_BASE + RO_REGS)
        rd_val = status_i[(32'(pg) * RO_REGS + 32'(addr_nx) - RO_BASE) * 8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= 5'd0;
      is_rd  <= 1'b0;
      sh     <= 7'd0;
      addr_q <= 5'd0;
      out_sh <= 8'h00;
      page_q <= 8'h00;
      for (int p = 0; p < NPAGES; p++)
        for (int r = 0; r < RW_REGS; r++)
          rw_q[p][r] <= 8'h00;
    end else if (!active) begin
      cnt   <= 5'd0;
      is_rd <= 1'b0;
    end else if (rise && cnt < 5'd16) begin
      sh  <= {sh[5:0], d};
      cnt <= cnt + 5'd1;
      if (cnt == 5'd0) is_rd <= d;
      if (cnt == 5'd7) begin
        addr_q <= addr_nx;
        if (is_rd) out_sh <= rd_val;
      end
      if (cnt == 5'd15 && !is_rd) begin
        if (addr_q == PAGE_ADDR)
          page_q <= wdata;
        else if (page_ok && 32'(addr_q) < RW_REGS)
          rw_q[pg][addr_q[RIW-1:0]] <= wdata;
      end
    end else if (fall && is_rd && cnt >= 5'd9 && cnt <= 5'd15)
      out_sh <= {out_sh[6:0], 1'b0};

  wire rd_phase = active & is_rd & (cnt >= 5'd8);

  assign sdio_oe  = rd_phase & three_wire;
  assign sdio_out = out_sh[7];
  assign sdo      = rd_phase & ~three_wire & out_sh[7];

  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    for (genvar r = 0; r < RW_REGS; r++) begin : g_reg
      if (PAGE_MASK[p]) begin : g_pop
        assign cfg_o[(p*RW_REGS + r)*8 +: 8] = rw_q[p][r];
      end else begin : g_empty
        assign cfg_o[(p*RW_REGS + r)*8 +: 8] = 8'h00;
      end
    end
  end
endmodule

// File: rtl/cfg_page_bank_chk.sv
module cfg_page_bank_chk #(
  parameter int CW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sdio_oe,
  input logic          sdo,
  input logic [CW-1:0] cfg_o
);
  logic [1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           hi_cnt <= 2'd0;
    else if (!cs_n)       hi_cnt <= 2'd0;
    else if (hi_cnt != 3) hi_cnt <= hi_cnt + 2'd1;

  wire quiet = (hi_cnt == 2'd3);

  a_r2_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (!sdio_oe && !sdo));
  a_r2_idle_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> $stable(cfg_o));
  a_r3_sdo_quiet_3wire: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[0] |-> !sdo);
  a_r4_no_drive_4wire: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_o[0] |-> !sdio_oe);
endmodule

bind cfg_page_bank cfg_page_bank_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
  .sdio_oe(sdio_oe), .sdo(sdo), .cfg_o(cfg_o)
);

// File: tb/test_cfg_page_bank.sv
module test_cfg_page_bank;
  localparam int NP = 8, RWN = 4, RON = 4;
  localparam int CW = NP * RWN * 8, SW = NP * RON * 8;
  localparam logic [7:0] MASK = 8'hF5;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdio_in = 0;
  logic sdio_out, sdio_oe, sdo;
  logic [CW-1:0] cfg_o;
  logic [SW-1:0] status_i;

  cfg_page_bank i_cfg_page_bank (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
    .cfg_o(cfg_o), .status_i(status_i));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] m_rw [NP][RWN];
  logic [7:0] m_page;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ck(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    if (a == 5'h1F) return m_page;
    if (m_page >= NP || !MASK[m_page[2:0]]) return 8'h00;
    if (a < RWN) return m_rw[m_page[2:0]][a[1:0]];
    if (a >= 16 && a < 16 + RON) return status_i[(m_page * RON + a - 16) * 8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic [CW-1:0] exp_cfg();
    logic [CW-1:0] v = '0;
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < RWN; r++)
        if (MASK[p]) v[(p*RWN + r)*8 +: 8] = m_rw[p][r];
    return v;
  endfunction

  task automatic model_reset();
    m_page = 8'h00;
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < RWN; r++) m_rw[p][r] = 8'h00;
  endtask

  task automatic xfer(input bit rd, input logic [4:0] a, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rv, output bit bad);
    logic [15:0] fr = {rd, 2'b00, a, wd};
    bit m3 = m_rw[0][0][0];
    rv = 8'h00;
    bad = 0;
    cs_n = 0;
    wt(8);
    for (int i = 0; i < nbits; i++) begin
      sdio_in = fr[15-i];
      wt(4);
      if (i >= 8) begin
        rv[15-i] = m3 ? sdio_out : sdo;
        if (sdio_oe !== (rd && m3)) bad = 1;
        if ((m3 || !rd) && sdo !== 1'b0) bad = 1;
      end else if (sdio_oe !== 1'b0 || sdo !== 1'b0) bad = 1;
      sclk = 1;
      wt(8);
      sclk = 0;
      wt(4);
    end
    wt(4);
    cs_n = 1;
    wt(8);
    if (!rd && nbits == 16) begin
      if (a == 5'h1F) m_page = wd;
      else if (m_page < NP && MASK[m_page[2:0]] && a < RWN) m_rw[m_page[2:0]][a[1:0]] = wd;
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] rv;
    bit bad;
    xfer(0, a, d, 16, rv, bad);
    ck("R3 R4 pins during write", CW'(bad), '0);
  endtask

  task automatic do_rd(input string req, input logic [4:0] a);
    logic [7:0] rv;
    bit bad;
    logic [7:0] e = exp_read(a);
    xfer(1, a, 8'h00, 16, rv, bad);
    ck(req, CW'(rv), CW'(e));
    ck("R3 R4 pin use on read", CW'(bad), '0);
  endtask

  initial begin
    logic [7:0] rv;
    bit bad;
    void'($urandom(32'd2024));
    for (int w = 0; w < SW / 32; w++) status_i[w*32 +: 32] = $urandom;
    model_reset();
    wt(5);
    ck("R9 reset cfg", cfg_o, '0);
    ck("R9 reset pins", CW'({sdio_oe, sdo}), '0);
    rst_n = 1;
    wt(4);
    do_rd("R9 R5 page after reset", 5'h1F);

    do_wr(5'd0, 8'h5A);
    do_rd("R6 R4 readback 4-wire", 5'd0);
    ck("R6 cfg after write", cfg_o, exp_cfg());
    do_wr(5'd0, 8'h01);
    do_wr(5'd3, 8'hE7);
    do_rd("R3 readback 3-wire", 5'd3);

    do_wr(5'h1F, 8'h02);
    do_rd("R5 page register", 5'h1F);
    do_wr(5'd1, 8'hC3);
    ck("R5 R6 page 2 field", CW'(cfg_o[(2*RWN + 1)*8 +: 8]), CW'(8'hC3));
    do_wr(5'd17, 8'hFF);
    do_rd("R7 read-only ignores write", 5'd17);

    do_wr(5'h1F, 8'h01);
    do_wr(5'd0, 8'h77);
    ck("R8 write to empty page", cfg_o, exp_cfg());
    do_rd("R8 empty page reads zero", 5'd0);
    do_rd("R5 page register from page 1", 5'h1F);
    do_wr(5'h1F, 8'h00);
    do_rd("R8 unused address", 5'd9);

    xfer(0, 5'd2, 8'hAA, 12, rv, bad);
    ck("R1 short transfer writes nothing", cfg_o, exp_cfg());

    for (int i = 0; i < 16; i++) begin
      sdio_in = 1'($urandom);
      wt(2);
      sclk = 1;
      wt(4);
      if (sdio_oe !== 1'b0 || sdo !== 1'b0) bad = 1;
      sclk = 0;
      wt(2);
    end
    ck("R2 idle pins", CW'({sdio_oe, sdo}), '0);
    ck("R2 idle cfg", cfg_o, exp_cfg());

    for (int n = 0; n < 150; n++) begin
      int pick = int'($urandom % 8);
      logic [4:0] a;
      logic [7:0] d = 8'($urandom);
      case (pick)
        0:       a = 5'h1F;
        1, 2, 3: a = 5'($urandom % 4);
        4, 5:    a = 5'(16 + $urandom % 4);
        6:       a = 5'($urandom);
        default: a = 5'd0;
      endcase
      if (a == 5'h1F) d = 8'($urandom % 10);
      if ($urandom % 2) do_rd("R1 R6 R7 R8 random read", a);
      else do_wr(a, d);
      ck("R6 R8 random cfg", cfg_o, exp_cfg());
    end

    rst_n = 0;
    wt(3);
    model_reset();
    ck("R9 mid-run reset cfg", cfg_o, '0);
    rst_n = 1;
    wt(4);
    do_rd("R9 page cleared", 5'h1F);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule